// File: doc/BRIEF.md
# Three-by-Three Unsigned Array Multiplier

This block multiplies two 3-bit unsigned operands and produces their full 6-bit product in one combinational pass. It contains no storage of any kind and does not use a behavioural multiply operator. Two-input AND gates form the nine partial products. An array of one-bit full adders sums them column by column. A carry ripples along each adder row into the next column, and each row passes its upper sums down to the next row.

The block sits in a datapath wherever a small product is needed in the same cycle as its operands. The operand width is a parameter, so the same structure scales. At the default width the array holds exactly six full adders. The path from operands to product is purely combinational, so the caller registers around the block as its timing requires.

Top module: `amul3`

## Requirements
- R1: For every pair of operand values, `prod` equals the unsigned integer product `mcand * mplier`, zero-extended to 6 bits.
- R2: When either operand is zero, `prod` is zero.
- R3: With both operands at their largest value 3'b111, `prod` is 6'b110001 (decimal 49).
- R4: Bit 0 of `prod` equals `mcand[0] & mplier[0]`.
- R5: `prod` never exceeds 49, the square of the largest operand.
- R6: `prod` responds to the operands alone. It holds no state, so the same operand pair always gives the same product, whatever pairs were applied before it.
- R7: Multiplication is commutative at the ports: swapping the operands gives the same `prod`.
- R8: When one operand is 1, `prod` equals the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 3 | Multiplicand, unsigned |
| mplier | input | 3 | Multiplier, unsigned |
| prod | output | 6 | Unsigned product of the two operands |

## Verification
The block has no state, so every fault lies in a gate or in the wiring of a gate. Such a fault shows at the ports within the same evaluation as the operand pair that exercises it. A broken carry link or a swapped partial product corrupts only the columns above that point. It therefore shows up only for operand pairs whose partial products reach that adder. This is why all 64 operand pairs are applied. Each pair is then compared bit for bit against the integer product. The bench also checks commutation, zero operands, a unit operand and the all-ones corner.

// File: rtl/amul_pkg.sv
package amul_pkg;
  // Operand width used by default across the multiplier.
  parameter int unsigned AMUL_W = 3;

  // Full-adder count of a ripple array multiplier of width w.
  function automatic int unsigned amul_fa_count(input int unsigned w);
    return w * (w - 1);
  endfunction

  // Largest possible product for width w.
  function automatic int unsigned amul_max_prod(input int unsigned w);
    return ((1 << w) - 1) * ((1 << w) - 1);
  endfunction
endpackage

// File: rtl/amul_full_adder.sv
module amul_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half_sum;

  always_comb begin
    half_sum = x_i ^ y_i;
    s_o      = half_sum ^ c_i;
    c_o      = (x_i & y_i) | (c_i & half_sum);
  end
endmodule

// File: rtl/amul_and_plane.sv
module amul_and_plane #(
  parameter int unsigned N = amul_pkg::AMUL_W
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] pp_o [N]
);
  // pp_o[r][j] = a[j] & b[r] : one two-input AND gate per term.
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp_o[r][j] = a_i[j] & b_i[r];
    end
  end
endmodule

// File: rtl/amul_adder_row.sv
module amul_adder_row #(
  parameter int unsigned N = amul_pkg::AMUL_W
) (
  input  logic [N-1:0] pp_i,
  input  logic [N-1:0] acc_i,
  output logic         lo_o,
  output logic [N-1:0] acc_o
);
  logic [N-1:0] sum;
  logic [N-1:0] cy;

  for (genvar j = 0; j < N; j++) begin : g_fa
    logic cin;
    if (j == 0) begin : g_first
      assign cin = 1'b0;  // unused carry input tied low
    end else begin : g_chain
      assign cin = cy[j-1];
    end
    amul_full_adder u_fa (
      .x_i (pp_i[j]),
      .y_i (acc_i[j]),
      .c_i (cin),
      .s_o (sum[j]),
      .c_o (cy[j])
    );
  end

  // The lowest sum is a finished product bit; the rest shift down one place.
  assign lo_o = sum[0];
  for (genvar j = 0; j < N - 1; j++) begin : g_shift
    assign acc_o[j] = sum[j+1];
  end
  assign acc_o[N-1] = cy[N-1];
endmodule

// File: rtl/amul3.sv
module amul3 #(
  parameter int unsigned N = amul_pkg::AMUL_W
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] prod
);
  logic [N-1:0] pp  [N];
  logic [N-1:0] acc [N];
  logic [N-1:0] lo;

  amul_and_plane #(.N(N)) u_plane (
    .a_i  (mcand),
    .b_i  (mplier),
    .pp_o (pp)
  );

  // Row zero: its bit 0 is final; the rest seed the first adder row.
  assign lo[0]  = pp[0][0];
  assign acc[0] = {1'b0, pp[0][N-1:1]};

  for (genvar r = 1; r < N; r++) begin : g_rows
    amul_adder_row #(.N(N)) u_row (
      .pp_i  (pp[r]),
      .acc_i (acc[r-1]),
      .lo_o  (lo[r]),
      .acc_o (acc[r])
    );
  end

  assign prod = {acc[N-1], lo};
endmodule

// File: rtl/amul3_chk.sv
module amul3_chk #(
  parameter int unsigned N = amul_pkg::AMUL_W
) (
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] prod
);
  localparam int unsigned MAXP = amul_pkg::amul_max_prod(N);

  always_comb begin
    assert_product_R1: assert final (prod == (2*N)'(mcand) * (2*N)'(mplier))
      else $error("R1 product mismatch");
    assert_zero_R2: assert final (!(mcand == '0 || mplier == '0) || prod == '0)
      else $error("R2 zero operand gave nonzero product");
    assert_corner_R3: assert final (!(&mcand && &mplier) || prod == (2*N)'(MAXP))
      else $error("R3 all-ones corner wrong");
    assert_lsb_R4: assert final (prod[0] == (mcand[0] & mplier[0]))
      else $error("R4 bit zero wrong");
    assert_bound_R5: assert final (int'(prod) <= int'(MAXP))
      else $error("R5 product out of range");
    assert_unit_R8: assert final (mplier != N'(1) || prod == (2*N)'(mcand))
      else $error("R8 unit operand wrong");
  end
endmodule

bind amul3 amul3_chk #(.N(N)) u_amul3_chk (.*);

// File: tb/tb_amul3.sv
module tb_amul3;
  localparam int unsigned N = 3;

  typedef struct {
    logic [N-1:0]   a;
    logic [N-1:0]   b;
    logic [2*N-1:0] exp;
  } item_t;

  logic clk;
  logic [N-1:0]   mcand;
  logic [N-1:0]   mplier;
  logic [2*N-1:0] prod;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  item_t sb[$];
  logic [2*N-1:0] seen [8][8];

  amul3 #(.N(N)) dut (.mcand(mcand), .mplier(mplier), .prod(prod));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  task automatic check(input string req, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d",
               req, mcand, mplier, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b);
    item_t it;
    @(posedge clk);
    mcand  = N'(a);
    mplier = N'(b);
    it.a   = N'(a);
    it.b   = N'(b);
    it.exp = (2*N)'(a * b);
    sb.push_back(it);
  endtask

  // Monitor: pops expected items and compares at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check("R1", prod, it.exp);
        check("R4", {5'b0, prod[0]}, {5'b0, it.a[0] & it.b[0]});
        if (it.a == 0 || it.b == 0) check("R2", prod, '0);
        if (it.a == 7 && it.b == 7) check("R3", prod, 6'b110001);
        if (prod > 6'd49) check("R5", prod, 6'd49);
        if (it.b == 1) check("R8", prod, (2*N)'(it.a));
        if (it.a == 1) check("R8", prod, (2*N)'(it.b));
        seen[it.a][it.b] = prod;
      end
    end
  end

  initial begin
    #200000ns;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mcand  = '0;
    mplier = '0;
    // Idle state: both operands zero (R2).
    drive(0, 0);
    // Exhaustive sweep, ascending (R1).
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        drive(a, b);
    // Corner, then a descending sweep to expose any history effect (R6).
    drive(7, 7);
    for (int k = 63; k >= 0; k--) drive(k / 8, k % 8);
    // Alternating extremes (R6).
    drive(7, 7); drive(0, 7); drive(7, 0); drive(5, 2); drive(2, 5);
    @(negedge clk);
    @(negedge clk);
    // Commutation over recorded products (R7).
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        checks++;
        if (seen[a][b] !== seen[b][a]) begin
          errors++;
          $display("FAIL R7 a=%0d b=%0d actual=%0d expected=%0d",
                   a, b, seen[a][b], seen[b][a]);
        end
      end
    // Repeatability after reordering: replay and compare to first result (R6).
    for (int a = 0; a < 8; a++) begin
      @(posedge clk);
      mcand  = N'(a);
      mplier = N'(7 - a);
      @(negedge clk);
      checks++;
      if (prod !== seen[a][7-a]) begin
        errors++;
        $display("FAIL R6 a=%0d b=%0d actual=%0d expected=%0d",
                 a, 7 - a, prod, seen[a][7-a]);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule